// File: doc/BRIEF.md
# Round-Robin ADC Read Scanner

This block is the host-side controller for an 8-bit multiplexed converter that is run in its pipelined read mode. In that mode each read strobe latches a new channel address and starts a conversion, and the byte put on the data bus during the same strobe is the result of the conversion started by the strobe before it. The scanner produces the chip-select, read strobe and channel address itself. It steps through the channels in round-robin order and captures the data bus once per strobe. It then publishes every byte as a one-clock result tagged with the channel that byte really belongs to.

The strobe frame is a count of clock cycles. A short setup phase asserts chip-select with the address already driven. A read-low phase follows, long enough to cover the converter's data access time. A hold phase keeps the address and chip-select steady after the read strobe rises. A gap then stretches the frame to the minimum spacing between strobes. A mode input selects a four-channel or eight-channel scan. A scan enable starts and pauses scanning, and a pause always lets the current frame finish.

Top module: `rr_adc_scanner`

## Requirements
- R1: After reset and until scanning starts, chip-select and read are both high (inactive) and result valid is low.
- R2: Read is low only while chip-select is low. The address is driven in the cycle chip-select falls and stays unchanged until chip-select rises. Chip-select rises exactly HOLD_CYC cycles after read rises.
- R3: Read stays low for exactly STROBE_CYC cycles. The data bus is sampled on the clock edge at which read returns high.
- R4: Successive falling edges of read are at least PERIOD_CYC cycles apart.
- R5: The channel address advances by one per strobe from 0 and wraps to 0 after the last enabled channel. The last channel is 3 when wide mode is 0 and 7 when wide mode is 1.
- R6: Each published result carries the channel addressed by the previous strobe. Its data is the bus value sampled during the current strobe.
- R7: The byte captured by the first strobe after reset is dropped, so no valid result is produced for that strobe.
- R8: If wide mode differs at a frame start from its value at the previous frame start, that strobe addresses channel 0 and its captured byte is dropped.
- R9: Result valid is high for exactly one clock per kept result. That clock is the first cycle in which read is high again after the strobe.
- R10: With scan enable low, no new frame starts once the current one ends. On resume the channel sequence continues where it stopped, and the first result after the pause is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Start or continue scanning; low pauses after the current frame |
| wide_mode | input | 1 | 0 = scan channels 0..3, 1 = scan channels 0..7 |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_addr | output | ADDR_W | Channel address driven to the converter |
| adc_data | input | DATA_W | Converter data bus |
| res_valid | output | 1 | One-clock pulse marking a result |
| res_chan | output | ADDR_W | Channel the result belongs to |
| res_data | output | DATA_W | Result byte |

## Verification
The assertions cover the strobe timing on every cycle: read nested inside chip-select, the address steady through a selection, the read width, the minimum spacing between strobes, the single-cycle valid pulse aligned with read rising, and a restart to channel 0 after a mode change. The correct channel tag on each result, the dropping of bytes after reset and after a mode change, the wrap point in each mode, and the continuity of the sequence across a pause depend on history over many strobes. Those can only be shown by the bench. Its converter model returns the previous conversion's value on each strobe.

// File: rtl/rr_adc_scanner_pkg.sv
package rr_adc_scanner_pkg;

  typedef enum logic [1:0] {
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_GAP
  } frame_phase_e;

  // Phase of a frame at tick t for the given phase lengths.
  function automatic frame_phase_e phase_at(int unsigned t, int unsigned setup_c,
                                            int unsigned strobe_c, int unsigned hold_c);
    if (t < setup_c)                            return PH_SETUP;
    else if (t < setup_c + strobe_c)            return PH_STROBE;
    else if (t < setup_c + strobe_c + hold_c)   return PH_HOLD;
    else                                        return PH_GAP;
  endfunction

  // Highest channel index scanned in the selected mode.
  function automatic int unsigned top_channel(logic wide, int unsigned narrow_n,
                                              int unsigned wide_n);
    return wide ? (wide_n - 1) : (narrow_n - 1);
  endfunction

  // Round-robin successor with wrap to zero.
  function automatic int unsigned wrap_next(int unsigned c, int unsigned top);
    return (c >= top) ? 0 : c + 1;
  endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer
  import rr_adc_scanner_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 7,
  parameter int unsigned HOLD_CYC   = 2,
  parameter int unsigned PERIOD_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  output logic cs_n,
  output logic rd_n,
  output logic frame_go,
  output logic capture
);

  localparam int unsigned TICK_W = $clog2(PERIOD_CYC);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(PERIOD_CYC - 1);
  localparam logic [TICK_W-1:0] CAP_TICK  = TICK_W'(SETUP_CYC + STROBE_CYC - 1);

  logic              running_q, running_nxt;
  logic [TICK_W-1:0] tick_q, tick_nxt;
  frame_phase_e      phase_nxt;

  always_comb begin
    frame_go = scan_en && (!running_q || (tick_q == LAST_TICK));
    capture  = running_q && (tick_q == CAP_TICK);
    if (frame_go) begin
      running_nxt = 1'b1;
      tick_nxt    = '0;
    end else if (!running_q) begin
      running_nxt = 1'b0;
      tick_nxt    = tick_q;
    end else if (tick_q == LAST_TICK) begin
      running_nxt = 1'b0;
      tick_nxt    = '0;
    end else begin
      running_nxt = 1'b1;
      tick_nxt    = tick_q + 1'b1;
    end
    phase_nxt = phase_at(32'(tick_nxt), SETUP_CYC, STROBE_CYC, HOLD_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      tick_q    <= '0;
      cs_n      <= 1'b1;
      rd_n      <= 1'b1;
    end else begin
      running_q <= running_nxt;
      tick_q    <= tick_nxt;
      cs_n      <= !(running_nxt && (phase_nxt != PH_GAP));
      rd_n      <= !(running_nxt && (phase_nxt == PH_STROBE));
    end
  end

endmodule

// File: rtl/chan_sequencer.sv
module chan_sequencer
  import rr_adc_scanner_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned NARROW_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_go,
  input  logic              capture,
  input  logic              wide_mode,
  output logic [ADDR_W-1:0] drive_chan,
  output logic [ADDR_W-1:0] tag_chan,
  output logic              tag_ok,
  output logic              mode_restart
);

  localparam int unsigned WIDE_CH = 1 << ADDR_W;

  logic [ADDR_W-1:0] issue_q;
  logic              mode_q;
  logic [ADDR_W-1:0] start_chan;
  int unsigned       top_idx;

  always_comb begin
    mode_restart = (wide_mode != mode_q);
    start_chan   = mode_restart ? '0 : issue_q;
    top_idx      = top_channel(wide_mode, NARROW_CH, WIDE_CH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q    <= '0;
      mode_q     <= 1'b0;
      drive_chan <= '0;
      tag_chan   <= '0;
      tag_ok     <= 1'b0;
    end else begin
      if (frame_go) begin
        mode_q     <= wide_mode;
        drive_chan <= start_chan;
        issue_q    <= ADDR_W'(wrap_next(32'(start_chan), top_idx));
        if (mode_restart) tag_ok <= 1'b0;
      end
      if (capture) begin
        tag_chan <= drive_chan;
        tag_ok   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/result_tagger.sv
module result_tagger #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              tag_ok,
  input  logic [ADDR_W-1:0] tag_chan,
  input  logic [DATA_W-1:0] bus_data,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_chan,
  output logic [DATA_W-1:0] res_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= capture && tag_ok;
      if (capture) begin
        res_chan <= tag_chan;
        res_data <= bus_data;
      end
    end
  end

endmodule

// File: rtl/rr_adc_scanner.sv
module rr_adc_scanner #(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NARROW_CH  = 4,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 7,
  parameter int unsigned HOLD_CYC   = 2,
  parameter int unsigned PERIOD_CYC = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              wide_mode,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic [ADDR_W-1:0] adc_addr,
  input  logic [DATA_W-1:0] adc_data,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_chan,
  output logic [DATA_W-1:0] res_data
);

  logic              frame_go;
  logic              capture;
  logic              tag_ok;
  logic              mode_restart;
  logic [ADDR_W-1:0] tag_chan;

  scan_timer #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .PERIOD_CYC(PERIOD_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .scan_en (scan_en),
    .cs_n    (adc_cs_n),
    .rd_n    (adc_rd_n),
    .frame_go(frame_go),
    .capture (capture)
  );

  chan_sequencer #(
    .ADDR_W   (ADDR_W),
    .NARROW_CH(NARROW_CH)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_go    (frame_go),
    .capture     (capture),
    .wide_mode   (wide_mode),
    .drive_chan  (adc_addr),
    .tag_chan    (tag_chan),
    .tag_ok      (tag_ok),
    .mode_restart(mode_restart)
  );

  result_tagger #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_tag (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .tag_ok   (tag_ok),
    .tag_chan (tag_chan),
    .bus_data (adc_data),
    .res_valid(res_valid),
    .res_chan (res_chan),
    .res_data (res_data)
  );

endmodule

// File: rtl/rr_adc_scanner_chk.sv
module rr_adc_scanner_chk #(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned STROBE_CYC = 7,
  parameter int unsigned PERIOD_CYC = 125
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic [ADDR_W-1:0] addr,
  input logic              res_valid,
  input logic              frame_go,
  input logic              capture,
  input logic              mode_restart,
  input logic              tag_ok
);

  localparam int unsigned CNT_W = $clog2(PERIOD_CYC + 1);
  localparam logic [CNT_W-1:0] STROBE_LEN = CNT_W'(STROBE_CYC);
  localparam logic [CNT_W-1:0] PERIOD_LEN = CNT_W'(PERIOD_CYC);

  logic             rd_prev;
  logic             armed;
  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W-1:0] gap_cnt;
  logic             rd_rise;
  logic             rd_fall;

  assign rd_rise = rd_n && !rd_prev;
  assign rd_fall = !rd_n && rd_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b1;
      armed   <= 1'b0;
      low_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      rd_prev <= rd_n;
      if (rd_n) low_cnt <= '0;
      else if (low_cnt != PERIOD_LEN) low_cnt <= low_cnt + 1'b1;
      if (rd_fall) begin
        gap_cnt <= CNT_W'(1);
        armed   <= 1'b1;
      end else if (gap_cnt != PERIOD_LEN) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  a_r2_rd_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);

  a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> $stable(addr));

  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |-> (low_cnt == STROBE_LEN));

  a_r3_capture_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !rd_n);

  a_r4_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && armed) |-> (gap_cnt >= PERIOD_LEN));

  a_r7_dropped_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !tag_ok) |=> !res_valid);

  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && mode_restart) |=> (addr == '0));

  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r9_valid_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(rd_n));

endmodule

bind rr_adc_scanner rr_adc_scanner_chk #(
  .ADDR_W    (ADDR_W),
  .STROBE_CYC(STROBE_CYC),
  .PERIOD_CYC(PERIOD_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (adc_cs_n),
  .rd_n        (adc_rd_n),
  .addr        (adc_addr),
  .res_valid   (res_valid),
  .frame_go    (frame_go),
  .capture     (capture),
  .mode_restart(mode_restart),
  .tag_ok      (tag_ok)
);

// File: tb/rr_adc_scanner_tb.sv
module rr_adc_scanner_tb;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int SETUP  = 1;
  localparam int STROBE = 7;
  localparam int HOLD   = 2;
  localparam int PERIOD = 125;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              scan_en = 1'b0;
  logic              wide_mode = 1'b0;
  logic              adc_cs_n, adc_rd_n;
  logic [ADDR_W-1:0] adc_addr;
  logic [DATA_W-1:0] adc_data = '0;
  logic              res_valid;
  logic [ADDR_W-1:0] res_chan;
  logic [DATA_W-1:0] res_data;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  rr_adc_scanner #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_CH(4),
    .SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .HOLD_CYC(HOLD), .PERIOD_CYC(PERIOD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .wide_mode(wide_mode),
    .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_addr(adc_addr),
    .adc_data(adc_data), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int succ(input int c, input logic wide);
    int top;
    top = wide ? 7 : 3;
    return (c >= top) ? 0 : c + 1;
  endfunction

  // Monitor and converter model state
  logic prev_rd, prev_cs, mode_b, first;
  int   rd_low_len, since_rise, since_fall, seen_fall;
  int   cs_addr, exp_ch, prev_ch;
  int   strobes = 0, rises = 0;
  logic [DATA_W-1:0] conv_val, show_val;
  bit   p_valid;
  int   p_chan, p_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_rd = 1'b1; prev_cs = 1'b1; first = 1'b1; mode_b = 1'b0;
      rd_low_len = 0; since_rise = 0; since_fall = 0; seen_fall = 0;
      cs_addr = 0; exp_ch = 0; prev_ch = 0; p_valid = 0;
      conv_val = 8'($urandom); show_val = '0;
    end else begin
      since_fall++;
      since_rise++;
      if (!adc_rd_n && adc_cs_n) chk(0, "R2 read low outside select", 1, 0);
      if (!adc_cs_n && !prev_cs && int'(adc_addr) != cs_addr)
        chk(0, "R2 address moved during select", int'(adc_addr), cs_addr);
      if (!adc_cs_n && prev_cs) cs_addr = int'(adc_addr);

      if (!adc_rd_n && prev_rd) begin
        bit drop;
        if (seen_fall) chk(since_fall >= PERIOD, "R4 strobe spacing", since_fall, PERIOD);
        since_fall = 0;
        seen_fall  = 1;
        drop = first || (wide_mode != mode_b);
        if (!first && wide_mode != mode_b) begin
          chk(adc_addr == 0, "R8 restart at channel 0", int'(adc_addr), 0);
          exp_ch = 0;
        end else begin
          if (first) exp_ch = 0;
          chk(int'(adc_addr) == exp_ch, "R5 scan order", int'(adc_addr), exp_ch);
        end
        first  = 1'b0;
        mode_b = wide_mode;
        p_valid = !drop;
        p_chan  = prev_ch;
        p_data  = int'(conv_val);
        show_val = conv_val;
        prev_ch = exp_ch;
        exp_ch  = succ(exp_ch, wide_mode);
        conv_val = 8'($urandom);
        adc_data = 8'($urandom);
        rd_low_len = 1;
        strobes++;
      end else if (!adc_rd_n) begin
        rd_low_len++;
        if (rd_low_len == 3) adc_data = show_val;
      end

      if (adc_rd_n && !prev_rd) begin
        chk(rd_low_len == STROBE, "R3 read width", rd_low_len, STROBE);
        if (p_valid) begin
          chk(res_valid == 1'b1, "R9 valid on read rise", int'(res_valid), 1);
          chk(int'(res_chan) == p_chan, "R6 result channel", int'(res_chan), p_chan);
          chk(int'(res_data) == p_data, "R6 R3 result data", int'(res_data), p_data);
        end else begin
          chk(res_valid == 1'b0, "R7 R8 dropped byte", int'(res_valid), 0);
        end
        adc_data = 8'($urandom);
        since_rise = 0;
        rises++;
      end else if (res_valid) begin
        chk(0, "R9 valid outside read rise", 1, 0);
      end

      if (adc_cs_n && !prev_cs) chk(since_rise == HOLD, "R2 address hold", since_rise, HOLD);
      prev_rd = adc_rd_n;
      prev_cs = adc_cs_n;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      chk(0, "watchdog expired", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic wait_strobes(input int n);
    int target;
    target = strobes + n;
    while (strobes < target) @(negedge clk);
  endtask

  task automatic wait_rise();
    int r;
    r = rises;
    while (rises == r) @(negedge clk);
  endtask

  task automatic toggle_mode();
    wait_rise();
    repeat (HOLD + 3) @(negedge clk);
    wide_mode = !wide_mode;
  endtask

  task automatic pause_and_resume();
    int s;
    wait_rise();
    scan_en = 1'b0;
    s = strobes;
    repeat (3 * PERIOD) @(negedge clk);
    chk(strobes == s, "R10 no strobe while paused", strobes - s, 0);
    chk(adc_cs_n && adc_rd_n, "R10 idle while paused", int'(adc_cs_n & adc_rd_n), 1);
    scan_en = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5CA7_0001));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    // R1: idle after reset with scanning off
    chk(adc_cs_n == 1'b1, "R1 chip-select idle", int'(adc_cs_n), 1);
    chk(adc_rd_n == 1'b1, "R1 read idle", int'(adc_rd_n), 1);
    chk(res_valid == 1'b0, "R1 no result", int'(res_valid), 0);
    chk(strobes == 0, "R10 no strobe before enable", strobes, 0);

    // Narrow scan across several wraps (R5, R7)
    scan_en = 1'b1;
    wait_strobes(10);
    // Wide scan, switched mid-sequence (R8)
    toggle_mode();
    wait_strobes(12);
    // Wide to narrow with the issue channel above 3
    toggle_mode();
    wait_strobes(6);
    pause_and_resume();
    wait_strobes(5);

    // Reset while running: idle state then first byte dropped again (R1, R7)
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(adc_cs_n && adc_rd_n && !res_valid, "R1 reset while running",
        int'(adc_cs_n & adc_rd_n & !res_valid), 1);
    rst_n = 1'b1;
    wait_strobes(4);

    // Random mix of runs, mode changes and pauses
    for (int i = 0; i < 40; i++) begin
      int act;
      wait_strobes(1 + int'($urandom % 12));
      act = int'($urandom % 4);
      if (act == 0) toggle_mode();
      else if (act == 1) pause_and_resume();
    end
    wait_strobes(3);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule